// File: doc/BRIEF.md
# Processor Clock-Stop Power-State Sequencer

This block steps a processor core through four nested power states: Running, Stop-Grant, Sleep and Deep Sleep. Three active-low request pins drive it. These are a stop-clock request, a sleep request and a deep-sleep request, and any of them may change at any time with no relation to the block's clock. An active-low reset returns the block to Running from any state. The block itself runs on a free-running, always-on clock.

The block drives three clock enables: one for the core units, one shared by the front-side-bus and interrupt-controller units, and one for the PLL. It also drives two acceptance flags, one telling upstream logic whether snoops may be taken and one telling it whether interrupts may be taken. When the core first stops, the block sends a one-cycle request for a Stop-Grant acknowledge bus transaction.

The states are nested. Sleep can be entered only from Stop-Grant, and Deep Sleep only from Sleep. The clock-gating cells, the PLL and the bus transaction itself sit outside this block. All outputs come straight from flops, so they never glitch.

Top module: `pwr_state_ctrl`

## Requirements
- R1: During and after reset the block is Running. In Running, core_clk_en, bus_clk_en, pll_en, snoop_ok and intr_ok are all 1, and sg_ack_req is 0. Reset is asynchronous, so these values appear as soon as rst_n goes low, from any state.
- R2: Each request pin passes through a synchronizer of SYNC_STAGES flops (default 2). A request change made before rising edge k first shows on the outputs after edge k+SYNC_STAGES+1, which is the fourth edge by default. It does not show after any earlier edge.
- R3: A low stop_req_n while Running moves the block to Stop-Grant. sg_ack_req is 1 for exactly the first cycle in which the Stop-Grant outputs are shown. sg_ack_req is never 1 at any other time, including on a return to Stop-Grant from Sleep.
- R4: In Stop-Grant, core_clk_en is 0. bus_clk_en, pll_en, snoop_ok and intr_ok are all 1.
- R5: A high stop_req_n in Stop-Grant returns the block to Running, with every enable and flag back at 1.
- R6: A low sleep_req_n in Stop-Grant moves the block to Sleep. A low sleep_req_n while Running has no effect, and Running never goes straight to Sleep or Deep Sleep.
- R7: In Sleep, pll_en is 1. core_clk_en, bus_clk_en, snoop_ok and intr_ok are all 0.
- R8: In Sleep, stop_req_n is ignored. A high sleep_req_n returns the block to Stop-Grant, which turns bus_clk_en back on and leaves core_clk_en off.
- R9: A low deep_req_n in Sleep moves the block to Deep Sleep. A low deep_req_n in Running or Stop-Grant has no effect.
- R10: In Deep Sleep every output is 0, including pll_en. stop_req_n and sleep_req_n are ignored. A high deep_req_n returns the block to Sleep.
- R11: In Stop-Grant, if stop_req_n goes high in the same cycle that sleep_req_n goes low, the block returns to Running and does not enter Sleep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req_n | input | 1 | Stop-clock request, active low, asynchronous |
| sleep_req_n | input | 1 | Sleep request, active low, asynchronous |
| deep_req_n | input | 1 | Deep-sleep request, active low, asynchronous |
| core_clk_en | output | 1 | Clock enable for the core units |
| bus_clk_en | output | 1 | Clock enable for the bus-interface and interrupt-controller units |
| pll_en | output | 1 | PLL enable |
| sg_ack_req | output | 1 | One-cycle request for a Stop-Grant acknowledge transaction |
| snoop_ok | output | 1 | Snoops may be accepted |
| intr_ok | output | 1 | Interrupts may be accepted |

## Verification
A request change reaches the outputs only after SYNC_STAGES+2 rising edges. SYNC_STAGES of these edges are spent in the synchronizer, one in the state register and one in the output register. The acknowledge pulse shares that last edge with the first Stop-Grant output values. The bench drives its inputs on falling edges and runs a reference model on a delay line of the same depth, then compares all six outputs at every falling edge. Its scenario checks look one edge before the due cycle, where the old value must still be present, and again at the due cycle. This pins each change to its exact cycle, and also shows that an ignored request never moves the outputs.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  typedef enum logic [1:0] {
    PS_RUN     = 2'd0,
    PS_STOPGNT = 2'd1,
    PS_SLEEP   = 2'd2,
    PS_DEEP    = 2'd3
  } pstate_e;

  typedef struct packed {
    logic core;
    logic bus;
    logic pll;
    logic snoop;
    logic intr;
  } clk_ctl_t;

  function automatic clk_ctl_t ctl_of(pstate_e s);
    clk_ctl_t c;
    unique case (s)
      PS_RUN:     c = '{core: 1'b1, bus: 1'b1, pll: 1'b1, snoop: 1'b1, intr: 1'b1};
      PS_STOPGNT: c = '{core: 1'b0, bus: 1'b1, pll: 1'b1, snoop: 1'b1, intr: 1'b1};
      PS_SLEEP:   c = '{core: 1'b0, bus: 1'b0, pll: 1'b1, snoop: 1'b0, intr: 1'b0};
      default:    c = '{core: 1'b0, bus: 1'b0, pll: 1'b0, snoop: 1'b0, intr: 1'b0};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int   WIDTH     = 3,
  parameter int   STAGES    = 2,
  parameter logic RST_LEVEL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  localparam logic [WIDTH-1:0] RST_WORD = {WIDTH{RST_LEVEL}};

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= RST_WORD;
          else        chain_q[g] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= RST_WORD;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    stop_act,
  input  logic    sleep_act,
  input  logic    deep_act,
  output pstate_e state_q,
  output logic    enter_sg_q
);

  pstate_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_RUN: begin
        if (stop_act) state_d = PS_STOPGNT;
      end
      PS_STOPGNT: begin
        if (!stop_act)     state_d = PS_RUN;
        else if (sleep_act) state_d = PS_SLEEP;
      end
      PS_SLEEP: begin
        if (!sleep_act)    state_d = PS_STOPGNT;
        else if (deep_act) state_d = PS_DEEP;
      end
      default: begin
        if (!deep_act) state_d = PS_SLEEP;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= PS_RUN;
      enter_sg_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      enter_sg_q <= (state_q == PS_RUN) && (state_d == PS_STOPGNT);
    end
  end

endmodule

// File: rtl/pwr_outdec.sv
module pwr_outdec
  import pwr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  pstate_e state_i,
  input  logic    enter_sg_i,
  output logic    core_clk_en,
  output logic    bus_clk_en,
  output logic    pll_en,
  output logic    snoop_ok,
  output logic    intr_ok,
  output logic    sg_ack_req
);

  localparam clk_ctl_t RST_CTL = ctl_of(PS_RUN);

  clk_ctl_t ctl_d, ctl_q;

  assign ctl_d = ctl_of(state_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q      <= RST_CTL;
      sg_ack_req <= 1'b0;
    end else begin
      ctl_q      <= ctl_d;
      sg_ack_req <= enter_sg_i;
    end
  end

  assign core_clk_en = ctl_q.core;
  assign bus_clk_en  = ctl_q.bus;
  assign pll_en      = ctl_q.pll;
  assign snoop_ok    = ctl_q.snoop;
  assign intr_ok     = ctl_q.intr;

endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req_n,
  input  logic sleep_req_n,
  input  logic deep_req_n,
  output logic core_clk_en,
  output logic bus_clk_en,
  output logic pll_en,
  output logic sg_ack_req,
  output logic snoop_ok,
  output logic intr_ok
);

  localparam int NREQ = 3;

  logic [NREQ-1:0] req_raw_n, req_sync_n;
  pstate_e         state_q;
  logic            enter_sg_q;

  assign req_raw_n = {deep_req_n, sleep_req_n, stop_req_n};

  pwr_sync #(
    .WIDTH    (NREQ),
    .STAGES   (SYNC_STAGES),
    .RST_LEVEL(1'b1)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(req_raw_n),
    .sync_o (req_sync_n)
  );

  pwr_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop_act  (~req_sync_n[0]),
    .sleep_act (~req_sync_n[1]),
    .deep_act  (~req_sync_n[2]),
    .state_q   (state_q),
    .enter_sg_q(enter_sg_q)
  );

  pwr_outdec u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_i    (state_q),
    .enter_sg_i (enter_sg_q),
    .core_clk_en(core_clk_en),
    .bus_clk_en (bus_clk_en),
    .pll_en     (pll_en),
    .snoop_ok   (snoop_ok),
    .intr_ok    (intr_ok),
    .sg_ack_req (sg_ack_req)
  );

endmodule

// File: rtl/pwr_state_ctrl_chk.sv
module pwr_state_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic core_clk_en,
  input logic bus_clk_en,
  input logic pll_en,
  input logic sg_ack_req,
  input logic snoop_ok,
  input logic intr_ok
);

  p_ack_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sg_ack_req |=> !sg_ack_req);

  p_ack_on_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sg_ack_req |-> (!core_clk_en && bus_clk_en && $past(core_clk_en)));

  p_stopgnt_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_clk_en |-> (snoop_ok && intr_ok && pll_en));

  p_run_no_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    core_clk_en |=> bus_clk_en);

  p_sleep_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_clk_en |-> (!snoop_ok && !intr_ok && !core_clk_en));

  p_wake_to_stopgnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_clk_en) |-> !core_clk_en);

  p_deep_from_sleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_en) |-> $past(!bus_clk_en));

  p_deep_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_en) |-> !bus_clk_en);

endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_clk_en(core_clk_en),
  .bus_clk_en (bus_clk_en),
  .pll_en     (pll_en),
  .sg_ack_req (sg_ack_req),
  .snoop_ok   (snoop_ok),
  .intr_ok    (intr_ok)
);

// File: tb/pwr_state_ctrl_tb_top.sv
module pwr_state_ctrl_tb_top;

  localparam int SYNC_STAGES = 2;
  localparam int LAT         = SYNC_STAGES + 2;

  // output word {core, bus, pll, snoop, intr, ack}
  localparam logic [5:0] O_RUN   = 6'b111110;
  localparam logic [5:0] O_SG    = 6'b011110;
  localparam logic [5:0] O_SGACK = 6'b011111;
  localparam logic [5:0] O_SLEEP = 6'b001000;
  localparam logic [5:0] O_DEEP  = 6'b000000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req_n = 1'b1, sleep_req_n = 1'b1, deep_req_n = 1'b1;
  logic core_clk_en, bus_clk_en, pll_en, sg_ack_req, snoop_ok, intr_ok;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwr_state_ctrl #(.SYNC_STAGES(SYNC_STAGES)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .stop_req_n(stop_req_n), .sleep_req_n(sleep_req_n), .deep_req_n(deep_req_n),
    .core_clk_en(core_clk_en), .bus_clk_en(bus_clk_en), .pll_en(pll_en),
    .sg_ack_req(sg_ack_req), .snoop_ok(snoop_ok), .intr_ok(intr_ok)
  );

  wire [5:0] dut_out = {core_clk_en, bus_clk_en, pll_en, snoop_ok, intr_ok, sg_ack_req};

  // reference model: states 0 run, 1 stop-grant, 2 sleep, 3 deep
  int         m_st;
  logic       m_ack;
  logic [5:0] m_out;
  logic [2:0] hist[$];
  logic [2:0] m_old;
  int         m_nx;

  function automatic logic [5:0] word_of(int st, logic ack);
    case (st)
      0:       return {5'b11111, ack};
      1:       return {5'b01111, ack};
      2:       return {5'b00100, ack};
      default: return {5'b00000, ack};
    endcase
  endfunction

  function automatic int next_of(int st, logic [2:0] r_n);
    logic stp, slp, dsl;
    stp = !r_n[2]; slp = !r_n[1]; dsl = !r_n[0];
    case (st)
      0: return stp ? 1 : 0;
      1: return !stp ? 0 : (slp ? 2 : 1);
      2: return !slp ? 1 : (dsl ? 3 : 2);
      default: return !dsl ? 2 : 3;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st  = 0;
      m_ack = 1'b0;
      m_out = O_RUN;
      hist.delete();
      for (int i = 0; i < SYNC_STAGES; i++) hist.push_back(3'b111);
    end else begin
      m_old = hist.pop_front();
      hist.push_back({stop_req_n, sleep_req_n, deep_req_n});
      m_nx  = next_of(m_st, m_old);
      m_out = word_of(m_st, m_ack);
      m_ack = (m_st == 0) && (m_nx == 1);
      m_st  = m_nx;
    end
  end

  task automatic check(input logic [5:0] act, input logic [5:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) check(dut_out, m_out, "R2 model compare");
  end

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // check one edge early (old value) and at the due edge (new value)
  task automatic due(input logic [5:0] old_w, input logic [5:0] new_w, input string tag);
    edges(LAT - 1);
    check(dut_out, old_w, {tag, " early"});
    edges(1);
    check(dut_out, new_w, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(dut_out, O_RUN, "R1 in reset");
    rst_n = 1'b1;
    edges(2);
    check(dut_out, O_RUN, "R1 after reset");

    stop_req_n = 1'b0;
    due(O_RUN, O_SGACK, "R2 R3 R4 stop-grant entry");
    edges(1);
    check(dut_out, O_SG, "R3 single ack R4");

    sleep_req_n = 1'b0;
    due(O_SG, O_SLEEP, "R6 R7 sleep entry");

    stop_req_n = 1'b1;
    edges(LAT + 2);
    check(dut_out, O_SLEEP, "R8 stop ignored in sleep");
    stop_req_n = 1'b0;

    deep_req_n = 1'b0;
    due(O_SLEEP, O_DEEP, "R9 R10 deep entry");

    sleep_req_n = 1'b1;
    stop_req_n  = 1'b1;
    edges(LAT + 2);
    check(dut_out, O_DEEP, "R10 stop/sleep ignored in deep");
    sleep_req_n = 1'b0;
    stop_req_n  = 1'b0;
    edges(LAT);

    deep_req_n = 1'b1;
    due(O_DEEP, O_SLEEP, "R10 deep exit to sleep");

    sleep_req_n = 1'b1;
    due(O_SLEEP, O_SG, "R8 sleep exit, no ack");

    deep_req_n = 1'b0;
    edges(LAT + 2);
    check(dut_out, O_SG, "R9 deep ignored in stop-grant");
    deep_req_n = 1'b1;
    edges(LAT);

    stop_req_n = 1'b1;
    due(O_SG, O_RUN, "R5 return to running");

    sleep_req_n = 1'b0;
    edges(LAT + 2);
    check(dut_out, O_RUN, "R6 sleep ignored in running");

    stop_req_n = 1'b0;
    due(O_RUN, O_SGACK, "R3 entry with sleep pending");
    edges(1);
    check(dut_out, O_SLEEP, "R6 sleep one cycle after stop-grant");

    sleep_req_n = 1'b1;
    due(O_SLEEP, O_SG, "R8 back to stop-grant");

    stop_req_n  = 1'b1;
    sleep_req_n = 1'b0;
    due(O_SG, O_RUN, "R11 stop release wins");
    edges(LAT + 2);
    check(dut_out, O_RUN, "R11 stays running");

    stop_req_n = 1'b0;
    deep_req_n = 1'b0;
    edges(3 * LAT);
    check(dut_out, O_DEEP, "R9 full descent");
    rst_n = 1'b0;
    #1;
    check(dut_out, O_RUN, "R1 async reset from deep");
    stop_req_n = 1'b1; sleep_req_n = 1'b1; deep_req_n = 1'b1;
    edges(2);
    rst_n = 1'b1;
    edges(LAT + 2);
    check(dut_out, O_RUN, "R1 running after reset release");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule